// File: doc/BRIEF.md
# Self-Triggered Sampling-Column Controller

This block steers a bank of analog sampling columns that a group of self-triggering front-end channels share during a particle-beam train. Whenever any channel's discriminator fires while the block is armed, it emits write strobes that capture every channel's charge into the column now in use. It also emits time strobes for the channels that fired. Beside the column it keeps a digital record: the coarse timestamp from a bunch-crossing counter, plus a hit flag and a gain flag for each channel. It then moves on to the next column.

After each capture the block stays locked until a bunch-crossing tick arrives, and then it rearms. A veto strobe, used when the last capture was noise, can give back the column most recently filled. This works only during a short window after the capture. The records are read back through a combinational select port once the train is over. Asserting the acquisition enable starts a new train, which wipes the records, the column pointer and the timestamp counter.

Top module: `sca_acq_ctrl`

## Requirements
- R1: After reset, `col_idx` is 0, `full` is 0, both strobe buses are 0, and every record reads back as all zeros.
- R2: The first clock edge at which `acq_en` is seen high after being low is a start edge. On it the column pointer goes to 0, every record is cleared, the timestamp counter goes to 0 and the trigger is armed. A discriminator input on that edge is ignored, so acquisition is live from the following edge.
- R3: While acquisition is live, the 12-bit timestamp advances by one on each edge with `bc_tick` high and wraps from 4095 to 0. A capture stores the value the counter holds before that edge's tick is applied.
- R4: A capture happens on an edge where acquisition is live, the block is armed, fewer than 16 columns are filled, at least one `disc` bit is high and no veto is honoured. For exactly the next cycle, `q_wr` is all ones and `t_wr` equals the `disc` vector of that edge. The record at index `col_idx` takes the timestamp, hit = `disc` and gain = `gain_sel`, and `col_idx` then rises by one.
- R5: After a capture the block is locked and ignores discriminators. It rearms on the first edge after the capture edge that has `bc_tick` high. A tick on the capture edge itself does not rearm it.
- R6: `full` is high exactly when `col_idx` equals 16. While full, discriminators are ignored and `col_idx` holds.
- R7: A veto is honoured only while acquisition is live and fewer than 2 `bc_tick` edges have passed since the latest capture, counting only edges after the capture edge. At most one veto is honoured per capture. An honoured veto lowers `col_idx` by one, clears `full` and zeroes the record of the column it returns. It does not change the armed state. Any other veto has no effect.
- R8: If a veto is honoured on the same edge as a capture would occur, the veto wins. The capture is dropped and no strobe is emitted.
- R9: `rec_bcid`, `rec_hit` and `rec_gain` show, in the same cycle, the record of the column selected by `rd_sel`.
- R10: While `acq_en` is low, discriminator inputs, ticks and vetoes change neither `col_idx`, `full` nor any record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_en | input | 1 | Acquisition enable; a rising level starts a train |
| bc_tick | input | 1 | Bunch-crossing tick, one cycle per crossing |
| disc | input | 36 | Discriminator output of each channel |
| gain_sel | input | 36 | Gain range used by each channel |
| veto | input | 1 | Request to give back the last filled column |
| rd_sel | input | 4 | Column whose record is shown |
| col_idx | output | 5 | Index of the next column to fill (0 to 16) |
| full | output | 1 | All 16 columns filled |
| q_wr | output | 36 | Per-channel charge-cell write strobe |
| t_wr | output | 36 | Per-channel time-cell write strobe |
| rec_bcid | output | 12 | Timestamp of the selected record |
| rec_hit | output | 36 | Hit flags of the selected record |
| rec_gain | output | 36 | Gain flags of the selected record |

## Verification
The assertions assume that `bc_tick`, `disc`, `veto` and `acq_en` are synchronous to `clk` and settle before each edge. They also assume that a train is not restarted while a veto is outstanding, so the window always refers to the latest capture of the current train. The stimulus is applied away from the active edge. It drives vetoes in and out of the window, coincident with ticks and with discriminator activity, and it drops and raises `acq_en` only between whole steps, so every combination the checks rely on arises from legal input sequences.

// File: rtl/amc_pkg.sv
package amc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_START = 2'd1,
    ACT_TRIG  = 2'd2,
    ACT_VETO  = 2'd3
  } act_e;

endpackage

// File: rtl/amc_bc_counter.sv
module amc_bc_counter #(
  parameter int BCW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           adv,
  output logic [BCW-1:0] bcid
);

  logic [BCW-1:0] bcid_q, bcid_d;

  always_comb begin
    bcid_d = bcid_q;
    if (clr)      bcid_d = '0;
    else if (adv) bcid_d = bcid_q + BCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcid_q <= '0;
    else        bcid_q <= bcid_d;
  end

  assign bcid = bcid_q;

  assert_bc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (bcid_q == $past(bcid_q) + BCW'(1)));

  assert_bc_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && (&bcid_q)) |=> (bcid_q == '0));

  assert_bc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(bcid_q));

endmodule

// File: rtl/amc_sequencer.sv
module amc_sequencer
  import amc_pkg::*;
#(
  parameter int NCOL       = 16,
  parameter int VETO_TICKS = 2,
  localparam int PW = $clog2(NCOL + 1),
  localparam int CW = $clog2(NCOL),
  localparam int WW = $clog2(VETO_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq_en,
  input  logic          bc_tick,
  input  logic          any_hit,
  input  logic          veto,
  output act_e          act,
  output logic [PW-1:0] ptr,
  output logic          full,
  output logic [CW-1:0] wr_col,
  output logic          bc_clr,
  output logic          bc_adv
);

  logic          acq_q;
  logic          armed_q, armed_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic [WW-1:0] win_q, win_d;
  logic          start, live, veto_ok, trig_ok;

  always_comb begin
    start   = acq_en && !acq_q;
    live    = acq_en && acq_q;
    veto_ok = live && veto && (win_q != '0);
    trig_ok = live && armed_q && (ptr_q != PW'(NCOL)) && any_hit && !veto_ok;

    if (start)        act = ACT_START;
    else if (veto_ok) act = ACT_VETO;
    else if (trig_ok) act = ACT_TRIG;
    else              act = ACT_NONE;
  end

  always_comb begin
    ptr_d   = ptr_q;
    armed_d = armed_q;
    win_d   = win_q;
    unique case (act)
      ACT_START: begin
        ptr_d   = '0;
        armed_d = 1'b1;
        win_d   = '0;
      end
      ACT_TRIG: begin
        ptr_d   = ptr_q + PW'(1);
        armed_d = 1'b0;
        win_d   = WW'(VETO_TICKS);
      end
      ACT_VETO: begin
        ptr_d = ptr_q - PW'(1);
        win_d = '0;
        if (bc_tick && !armed_q) armed_d = 1'b1;
      end
      default: begin
        if (live && bc_tick) begin
          if (!armed_q)       armed_d = 1'b1;
          if (win_q != '0)    win_d   = win_q - WW'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_q   <= 1'b0;
      armed_q <= 1'b0;
      ptr_q   <= '0;
      win_q   <= '0;
    end else begin
      acq_q   <= acq_en;
      armed_q <= armed_d;
      ptr_q   <= ptr_d;
      win_q   <= win_d;
    end
  end

  assign ptr    = ptr_q;
  assign full   = (ptr_q == PW'(NCOL));
  assign wr_col = (act == ACT_VETO) ? CW'(ptr_q - PW'(1)) : CW'(ptr_q);
  assign bc_clr = start;
  assign bc_adv = live && bc_tick;

  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PW'(NCOL));

  assert_trig_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_TRIG) |=> (ptr_q == $past(ptr_q) + PW'(1)) && !armed_q);

  assert_veto_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_VETO) |=> (ptr_q == $past(ptr_q) - PW'(1)) && !full);

  assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && acq_q && acq_en && !veto) |=> full);

  assert_locked_ignores_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && acq_q && acq_en && !veto) |=> $stable(ptr_q));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq_en) |=> $stable(ptr_q));

endmodule

// File: rtl/amc_col_store.sv
module amc_col_store #(
  parameter int NCH  = 36,
  parameter int NCOL = 16,
  parameter int BCW  = 12,
  localparam int CW = $clog2(NCOL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_all,
  input  logic           wr_en,
  input  logic [CW-1:0]  wr_col,
  input  logic [BCW-1:0] wr_bcid,
  input  logic [NCH-1:0] wr_hit,
  input  logic [NCH-1:0] wr_gain,
  input  logic [CW-1:0]  rd_sel,
  output logic [BCW-1:0] rd_bcid,
  output logic [NCH-1:0] rd_hit,
  output logic [NCH-1:0] rd_gain
);

  logic [NCOL-1:0][BCW-1:0] bcid_all;
  logic [NCOL-1:0][NCH-1:0] hit_all;
  logic [NCOL-1:0][NCH-1:0] gain_all;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [BCW-1:0] bcid_q;
    logic [NCH-1:0] hit_q, gain_q;
    logic           load;

    assign load = wr_en && (wr_col == CW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bcid_q <= '0;
        hit_q  <= '0;
        gain_q <= '0;
      end else if (clr_all) begin
        bcid_q <= '0;
        hit_q  <= '0;
        gain_q <= '0;
      end else if (load) begin
        bcid_q <= wr_bcid;
        hit_q  <= wr_hit;
        gain_q <= wr_gain;
      end
    end

    assign bcid_all[c] = bcid_q;
    assign hit_all[c]  = hit_q;
    assign gain_all[c] = gain_q;
  end

  always_comb begin
    rd_bcid = '0;
    rd_hit  = '0;
    rd_gain = '0;
    if (32'(rd_sel) < NCOL) begin
      rd_bcid = bcid_all[rd_sel];
      rd_hit  = hit_all[rd_sel];
      rd_gain = gain_all[rd_sel];
    end
  end

endmodule

// File: rtl/sca_acq_ctrl.sv
module sca_acq_ctrl
  import amc_pkg::*;
#(
  parameter int NCH        = 36,
  parameter int NCOL       = 16,
  parameter int BCW        = 12,
  parameter int VETO_TICKS = 2,
  localparam int PW = $clog2(NCOL + 1),
  localparam int CW = $clog2(NCOL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acq_en,
  input  logic           bc_tick,
  input  logic [NCH-1:0] disc,
  input  logic [NCH-1:0] gain_sel,
  input  logic           veto,
  input  logic [CW-1:0]  rd_sel,
  output logic [PW-1:0]  col_idx,
  output logic           full,
  output logic [NCH-1:0] q_wr,
  output logic [NCH-1:0] t_wr,
  output logic [BCW-1:0] rec_bcid,
  output logic [NCH-1:0] rec_hit,
  output logic [NCH-1:0] rec_gain
);

  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  act_e           act;
  logic [CW-1:0]  wr_col;
  logic           bc_clr, bc_adv;
  logic [BCW-1:0] bcid;
  logic           is_trig, wr_en;
  logic [BCW-1:0] wr_bcid;
  logic [NCH-1:0] wr_hit, wr_gain;
  logic [NCH-1:0] q_wr_q, q_wr_d, t_wr_q, t_wr_d;

  amc_sequencer #(.NCOL(NCOL), .VETO_TICKS(VETO_TICKS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync),
    .acq_en  (acq_en),
    .bc_tick (bc_tick),
    .any_hit (|disc),
    .veto    (veto),
    .act     (act),
    .ptr     (col_idx),
    .full    (full),
    .wr_col  (wr_col),
    .bc_clr  (bc_clr),
    .bc_adv  (bc_adv)
  );

  amc_bc_counter #(.BCW(BCW)) u_bc (
    .clk   (clk),
    .rst_n (rst_sync),
    .clr   (bc_clr),
    .adv   (bc_adv),
    .bcid  (bcid)
  );

  always_comb begin
    is_trig = (act == ACT_TRIG);
    wr_en   = is_trig || (act == ACT_VETO);
    wr_bcid = is_trig ? bcid     : '0;
    wr_hit  = is_trig ? disc     : '0;
    wr_gain = is_trig ? gain_sel : '0;
    q_wr_d  = is_trig ? '1       : '0;
    t_wr_d  = is_trig ? disc     : '0;
  end

  amc_col_store #(.NCH(NCH), .NCOL(NCOL), .BCW(BCW)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync),
    .clr_all (act == ACT_START),
    .wr_en   (wr_en),
    .wr_col  (wr_col),
    .wr_bcid (wr_bcid),
    .wr_hit  (wr_hit),
    .wr_gain (wr_gain),
    .rd_sel  (rd_sel),
    .rd_bcid (rec_bcid),
    .rd_hit  (rec_hit),
    .rd_gain (rec_gain)
  );

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      q_wr_q <= '0;
      t_wr_q <= '0;
    end else begin
      q_wr_q <= q_wr_d;
      t_wr_q <= t_wr_d;
    end
  end

  assign q_wr = q_wr_q;
  assign t_wr = t_wr_q;

  assert_strobe_shape_R4: assert property (@(posedge clk) disable iff (!rst_sync)
    (q_wr_q == '0) || (q_wr_q == '1));

  assert_time_within_charge_R4: assert property (@(posedge clk) disable iff (!rst_sync)
    (t_wr_q & ~q_wr_q) == '0);

  assert_strobe_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_sync)
    (q_wr_q != '0) |-> (t_wr_q != '0));

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    (q_wr_q != '0) |=> (q_wr_q == '0));

  assert_veto_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    (act == ACT_VETO) |=> (q_wr_q == '0));

endmodule

// File: tb/test_sca_acq_ctrl.sv
module test_sca_acq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 36;
  localparam int NCOL = 16;
  localparam int BCW  = 12;
  localparam int WIN  = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            acq_en, bc_tick, veto;
  logic [NCH-1:0]  disc, gain_sel;
  logic [3:0]      rd_sel;
  logic [4:0]      col_idx;
  logic            full;
  logic [NCH-1:0]  q_wr, t_wr, rec_hit, rec_gain;
  logic [BCW-1:0]  rec_bcid;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sca_acq_ctrl i_sca_acq_ctrl (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .bc_tick(bc_tick),
    .disc(disc), .gain_sel(gain_sel), .veto(veto), .rd_sel(rd_sel),
    .col_idx(col_idx), .full(full), .q_wr(q_wr), .t_wr(t_wr),
    .rec_bcid(rec_bcid), .rec_hit(rec_hit), .rec_gain(rec_gain)
  );

  // reference state derived from the requirements
  int             m_ptr;
  bit             m_acq_q, m_armed;
  int             m_win;
  int             m_bc;
  logic [NCH-1:0] m_qwr, m_twr;
  logic [BCW-1:0] m_rbc  [NCOL];
  logic [NCH-1:0] m_rhit [NCOL];
  logic [NCH-1:0] m_rgn  [NCOL];

  task automatic chk(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic [NCH-1:0] d, input logic [NCH-1:0] g,
                            input bit tk, input bit vt, input bit ac);
    bit start, live, vacc, tacc;
    start = ac && !m_acq_q;
    live  = ac && m_acq_q;
    vacc  = live && vt && (m_win != 0);
    tacc  = live && m_armed && (m_ptr < NCOL) && (d != '0) && !vacc;
    m_qwr = tacc ? '1 : '0;
    m_twr = tacc ? d  : '0;
    if (start) begin
      m_ptr = 0; m_armed = 1; m_win = 0; m_bc = 0;
      for (int c = 0; c < NCOL; c++) begin
        m_rbc[c] = '0; m_rhit[c] = '0; m_rgn[c] = '0;
      end
    end else if (live) begin
      if (vacc) begin
        m_ptr--;
        m_rbc[m_ptr] = '0; m_rhit[m_ptr] = '0; m_rgn[m_ptr] = '0;
        m_win = 0;
        if (tk) m_armed = 1;
      end else if (tacc) begin
        m_rbc[m_ptr] = BCW'(m_bc); m_rhit[m_ptr] = d; m_rgn[m_ptr] = g;
        m_ptr++;
        m_armed = 0;
        m_win = WIN;
      end else if (tk) begin
        m_armed = 1;
        if (m_win != 0) m_win--;
      end
      if (tk) m_bc = (m_bc + 1) % 4096;
    end
    m_acq_q = ac;
  endtask

  task automatic step(input logic [NCH-1:0] d, input logic [NCH-1:0] g,
                      input bit tk, input bit vt, input bit ac);
    disc = d; gain_sel = g; bc_tick = tk; veto = vt; acq_en = ac;
    @(posedge clk);
    model_edge(d, g, tk, vt, ac);
    @(negedge clk);
    chk("R4 col_idx", col_idx, m_ptr);
    chk("R6 full", full, (m_ptr == NCOL));
    chk("R4 q_wr", q_wr, m_qwr);
    chk("R4 t_wr", t_wr, m_twr);
  endtask

  task automatic sweep();
    disc = '0; bc_tick = 0; veto = 0;
    for (int c = 0; c < NCOL; c++) begin
      rd_sel = 4'(c);
      #1;
      chk("R9 rec_bcid", rec_bcid, m_rbc[c]);
      chk("R9 rec_hit", rec_hit, m_rhit[c]);
      chk("R9 rec_gain", rec_gain, m_rgn[c]);
    end
    @(negedge clk);
    m_qwr = '0; m_twr = '0;
  endtask

  task automatic pulse_trig(input logic [NCH-1:0] d, input logic [NCH-1:0] g);
    step(d, g, 0, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 250000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    rst_n = 0; acq_en = 0; bc_tick = 0; veto = 0; disc = '0; gain_sel = '0; rd_sel = '0;
    m_ptr = 0; m_acq_q = 0; m_armed = 0; m_win = 0; m_bc = 0; m_qwr = '0; m_twr = '0;
    for (int c = 0; c < NCOL; c++) begin
      m_rbc[c] = '0; m_rhit[c] = '0; m_rgn[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 col_idx", col_idx, 0);
    chk("R1 full", full, 0);
    chk("R1 q_wr", q_wr, 0);
    chk("R1 t_wr", t_wr, 0);
    sweep();

    // R2 start edge ignores discriminators
    step(36'h1, '0, 0, 0, 1);
    chk("R2 start ignores trigger", col_idx, 0);

    pulse_trig(36'h5, 36'h3);
    chk("R4 first capture", col_idx, 1);
    chk("R4 t_wr pattern", t_wr, 36'h5);

    // R5 locked until a tick
    pulse_trig(36'h1, '0);
    chk("R5 locked trigger ignored", col_idx, 1);
    step('0, '0, 1, 0, 1);
    pulse_trig(36'h2, 36'h2);
    chk("R5 rearmed after tick", col_idx, 2);

    // R7 veto inside window
    step('0, '0, 0, 1, 1);
    chk("R7 veto returns column", col_idx, 1);
    rd_sel = 4'd1; #1;
    chk("R7 vetoed record cleared", rec_hit, 0);
    step('0, '0, 1, 0, 1);
    step('0, '0, 0, 1, 1);
    chk("R7 second veto ignored", col_idx, 1);

    // R7 veto after the window closes
    pulse_trig(36'h4, '0);
    step('0, '0, 1, 0, 1);
    step('0, '0, 1, 0, 1);
    step('0, '0, 0, 1, 1);
    chk("R7 late veto ignored", col_idx, 2);

    // R8 veto beats a coincident trigger
    pulse_trig(36'h8, '0);
    step('0, '0, 1, 0, 1);
    step(36'h10, '0, 0, 1, 1);
    chk("R8 veto wins", col_idx, 2);
    chk("R8 no strobe", q_wr, 0);
    pulse_trig(36'h10, 36'h10);
    chk("R8 trigger later taken", col_idx, 3);

    // R6 fill to the end
    while (m_ptr < NCOL) begin
      step('0, '0, 1, 0, 1);
      pulse_trig(NCH'(m_ptr * 7 + 1) << m_ptr, NCH'(m_ptr * 3));
    end
    chk("R6 full at sixteen", full, 1);
    step('0, '0, 1, 0, 1);
    pulse_trig('1, '1);
    chk("R6 trigger while full ignored", col_idx, NCOL);
    sweep();

    // R10 acquisition off
    step('0, '0, 0, 0, 0);
    step('1, '1, 1, 0, 0);
    step('1, '0, 0, 1, 0);
    chk("R10 pointer holds", col_idx, NCOL);
    sweep();

    // R2 restart clears state
    step('0, '0, 0, 0, 1);
    chk("R2 restart pointer", col_idx, 0);
    chk("R2 restart full", full, 0);
    sweep();

    // R3 timestamp and wrap
    for (int i = 0; i < 5; i++) step('0, '0, 1, 0, 1);
    pulse_trig(36'h1, '0);
    rd_sel = 4'd0; #1;
    chk("R3 timestamp after five ticks", rec_bcid, 5);
    for (int i = 0; i < 4096; i++) step('0, '0, 1, 0, 1);
    pulse_trig(36'h2, '0);
    rd_sel = 4'd1; #1;
    chk("R3 timestamp wrapped", rec_bcid, 5);
    step('0, '0, 1, 0, 1);
    step(36'h4, '0, 1, 0, 1);
    rd_sel = 4'd2; #1;
    chk("R3 capture uses pre-tick value", rec_bcid, 6);

    // pseudo-random sweep against the reference
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 3000; i++) begin
      logic [NCH-1:0] d, g;
      bit tk, vt, ac;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      d  = (lf[2:0] == 3'd0) ? {lf[11:8], lf} : '0;
      g  = {lf[7:4], ~lf};
      tk = (lf[14:13] == 2'd0);
      vt = (lf[18:16] == 3'd0);
      ac = !((i % 400) >= 390);
      step(d, g, tk, vt, ac);
      if (i % 150 == 149) sweep();
    end
    sweep();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule